// File: doc/BRIEF.md
# Flash Erase Command Decoder

This block sits beside a NOR-flash style host bus and watches its write cycles. Each write is an address and a data byte, and it is taken when the active-low write enable returns high. When the host writes a complete six-write chip-erase or sector-erase command, the decoder sends a single start pulse to the erase engine. For a sector erase it also holds the address of the sector that the last write named.

The order of the writes is fixed. Two unlock writes come first, then a setup write, then two more unlock writes, then the erase code. Any write that breaks this order sends the decoder back to idle with nothing started. From the start pulse until the engine raises `erase_done`, the decoder is busy and ignores every write. Lowering `rst_n` aborts at once and returns the block to array-read mode, shown by `busy` low.

The write enable passes through a two-flop synchroniser. The host must hold `addr` and `data` stable from the falling edge of `we_n` until three clocks after its rising edge. The outputs are plain control pins. The start pulses have no back-pressure, so the engine must accept a pulse in the cycle it appears.

Top module: `erase_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and after reset, `busy`, `start_chip` and `start_sector` are 0 and `sector_addr` is 0.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 produce exactly one `start_chip` pulse, one clock wide, and `busy` rises in the same cycle.
- R3: The same five leading writes followed by 0x30 at any address produce one `start_sector` pulse. `sector_addr` then equals that sixth address and stays constant while busy.
- R4: A write whose address or data differs from the expected value at any of steps one to five returns the decoder to idle with no pulse and `busy` low. A complete sequence written after it is accepted.
- R5: A sixth write of 0x10 at an address other than 0x555 starts nothing.
- R6: While `busy` is high, writes are ignored: a complete sequence produces no pulse and `sector_addr` does not change.
- R7: An `erase_done` high for one clock while busy clears `busy` and returns `sector_addr` to 0. A new sequence is then accepted.
- R8: Driving `rst_n` low while busy clears `busy` without waiting for a clock edge.
- R9: A write is taken only on a rising edge of `we_n`. Holding `we_n` low takes nothing, and one low pulse counts as one write.
- R10: `erase_done` while idle has no effect on `busy` or `sector_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| we_n | input | 1 | Active-low host write enable; a write is taken on its rising edge |
| addr | input | ADDR_W | Host write address |
| data | input | DATA_W | Host write data |
| erase_done | input | 1 | Erase engine finished |
| start_chip | output | 1 | One-cycle chip-erase start pulse |
| start_sector | output | 1 | One-cycle sector-erase start pulse |
| busy | output | 1 | Erase running; low means array-read mode |
| sector_addr | output | ADDR_W | Latched sector address; 0 when no sector erase runs |

## Verification
The bench breaks the sequence at every step, once on the address and once on the data. A decoder that skipped a comparison or resynchronised on a stray unlock write would fire a pulse or stay partly armed, and a later sequence would then trigger early. It writes full sequences while an erase runs in each mode. A design that did not gate writes during busy would emit a second pulse or overwrite the latched sector. Erase-done while idle, a held-low write enable, and reset partway through an erase check that busy and the address latch clear only through their own causes.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_SETUP, ST_UNL3, ST_UNL4
  } seq_t;

  localparam int unsigned UNLK_ADDR_A = 32'h555;
  localparam int unsigned UNLK_ADDR_B = 32'h2AA;
  localparam int unsigned UNLK_DATA_A = 32'hAA;
  localparam int unsigned UNLK_DATA_B = 32'h55;
  localparam int unsigned SETUP_CODE  = 32'h80;
  localparam int unsigned CHIP_CODE   = 32'h10;
  localparam int unsigned SECT_CODE   = 32'h30;
endpackage

// File: rtl/erase_wr_sync.sv
module erase_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n_in,
  output logic wr_stb
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], we_n_in};
  end

  // rising edge of the synchronised enable marks the end of a write
  assign wr_stb = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit_chip,
  output logic              hit_sector
);
  localparam logic [ADDR_W-1:0] A_A = ADDR_W'(UNLK_ADDR_A);
  localparam logic [ADDR_W-1:0] A_B = ADDR_W'(UNLK_ADDR_B);
  localparam logic [DATA_W-1:0] D_A = DATA_W'(UNLK_DATA_A);
  localparam logic [DATA_W-1:0] D_B = DATA_W'(UNLK_DATA_B);
  localparam logic [DATA_W-1:0] D_S = DATA_W'(SETUP_CODE);
  localparam logic [DATA_W-1:0] D_C = DATA_W'(CHIP_CODE);
  localparam logic [DATA_W-1:0] D_E = DATA_W'(SECT_CODE);

  seq_t step, step_nx;
  logic is_a_a, is_b_b;

  assign is_a_a = (addr == A_A) && (data == D_A);
  assign is_b_b = (addr == A_B) && (data == D_B);

  always_comb begin
    step_nx    = ST_IDLE;
    hit_chip   = 1'b0;
    hit_sector = 1'b0;
    if (wr_stb && !hold) begin
      unique case (step)
        ST_IDLE:  if (is_a_a) step_nx = ST_UNL1;
        ST_UNL1:  if (is_b_b) step_nx = ST_UNL2;
        ST_UNL2:  if (addr == A_A && data == D_S) step_nx = ST_SETUP;
        ST_SETUP: if (is_a_a) step_nx = ST_UNL3;
        ST_UNL3:  if (is_b_b) step_nx = ST_UNL4;
        ST_UNL4: begin
          if (addr == A_A && data == D_C) hit_chip = 1'b1;
          else if (data == D_E)           hit_sector = 1'b1;
        end
        default: step_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               step <= ST_IDLE;
    else if (hold)            step <= ST_IDLE;
    else if (wr_stb)          step <= step_nx;
  end

  // R2
  hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_chip && hit_sector));
  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !hit_chip && !hit_sector);
endmodule

// File: rtl/erase_tracker.sv
module erase_tracker #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_chip,
  input  logic              hit_sector,
  input  logic [ADDR_W-1:0] addr,
  input  logic              erase_done,
  output logic              start_chip,
  output logic              start_sector,
  output logic              busy,
  output logic [ADDR_W-1:0] sector_addr
);
  logic sect_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_chip   <= 1'b0;
      start_sector <= 1'b0;
      busy         <= 1'b0;
      sect_run     <= 1'b0;
      sector_addr  <= '0;
    end else begin
      start_chip   <= hit_chip && !busy;
      start_sector <= hit_sector && !busy;
      if (busy) begin
        if (erase_done) begin
          busy        <= 1'b0;
          sect_run    <= 1'b0;
          sector_addr <= '0;
        end
      end else if (hit_chip) begin
        busy <= 1'b1;
      end else if (hit_sector) begin
        busy        <= 1'b1;
        sect_run    <= 1'b1;
        sector_addr <= addr;
      end
    end
  end

  // R2
  chip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_chip |=> !start_chip);
  // R2
  chip_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_chip || start_sector) |-> busy);
  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !start_chip && !start_sector);
  // R3
  sect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sect_run && $past(sect_run)) |-> $stable(sector_addr));
  // R7
  latch_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sector_addr == '0);
  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_done) |=> !busy);
endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              erase_done,
  output logic              start_chip,
  output logic              start_sector,
  output logic              busy,
  output logic [ADDR_W-1:0] sector_addr
);
  logic wr_stb, hit_chip, hit_sector;

  erase_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .we_n_in(we_n), .wr_stb(wr_stb)
  );

  erase_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .hold(busy),
    .addr(addr), .data(data), .hit_chip(hit_chip), .hit_sector(hit_sector)
  );

  erase_tracker #(.ADDR_W(ADDR_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .hit_chip(hit_chip), .hit_sector(hit_sector),
    .addr(addr), .erase_done(erase_done), .start_chip(start_chip),
    .start_sector(start_sector), .busy(busy), .sector_addr(sector_addr)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !busy && !start_chip && !start_sector);
endmodule

// File: tb/erase_cmd_decoder_test.sv
module erase_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  data = '0;
  logic        erase_done = 1'b0;
  logic        start_chip, start_sector, busy;
  logic [11:0] sector_addr;

  int checks = 0, errors = 0;
  int n_chip = 0, n_sect = 0;
  logic [11:0] seen_sa = '0;

  always #5 clk = ~clk;

  erase_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .data(data),
    .erase_done(erase_done), .start_chip(start_chip),
    .start_sector(start_sector), .busy(busy), .sector_addr(sector_addr)
  );

  always @(negedge clk) begin
    if (start_chip) n_chip++;
    if (start_sector) begin n_sect++; seen_sa = sector_addr; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data = d; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [11:0] step_addr(input int s);
    return (s == 1 || s == 4) ? 12'h2AA : 12'h555;
  endfunction
  function automatic logic [7:0] step_data(input int s);
    case (s)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      default: return 8'h80;
    endcase
  endfunction

  task automatic prefix();
    for (int s = 0; s < 5; s++) wr(step_addr(s), step_data(s));
  endtask

  task automatic done_pulse();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_counts();
    n_chip = 0; n_sect = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy in reset", busy, 0);
    chk("R1 sector_addr in reset", sector_addr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pulses after reset", n_chip + n_sect, 0);

    // R2 chip erase
    clear_counts();
    prefix(); wr(12'h555, 8'h10);
    chk("R2 chip pulse count", n_chip, 1);
    chk("R2 busy after chip", busy, 1);
    chk("R2 no sector pulse", n_sect, 0);

    // R6 writes during chip erase ignored
    clear_counts();
    prefix(); wr(12'h123, 8'h30);
    prefix(); wr(12'h555, 8'h10);
    chk("R6 pulses during chip busy", n_chip + n_sect, 0);
    chk("R6 sector_addr during chip busy", sector_addr, 0);

    // R7 completion
    done_pulse();
    chk("R7 busy cleared", busy, 0);

    // R3 sector sweep with R7 release
    for (int i = 0; i < 8; i++) begin
      logic [11:0] sa;
      sa = 12'((i * 12'h1F3 + 12'h040) & 12'hFFF);
      clear_counts();
      prefix(); wr(sa, 8'h30);
      chk("R3 sector pulse count", n_sect, 1);
      chk("R3 sector addr at pulse", seen_sa, sa);
      repeat (5) @(negedge clk);
      chk("R3 sector addr held", sector_addr, sa);
      if (i == 0) begin
        // R6 during sector erase
        prefix(); wr(12'h555, 8'h10);
        prefix(); wr(12'hABC, 8'h30);
        chk("R6 no pulse during sector busy", n_chip + n_sect, 1);
        chk("R6 sector addr unchanged", sector_addr, sa);
      end
      done_pulse();
      chk("R7 sector_addr released", sector_addr, 0);
      chk("R7 busy low", busy, 0);
    end

    // R4 break each step on address and on data
    for (int p = 0; p < 5; p++) begin
      for (int k = 0; k < 2; k++) begin
        clear_counts();
        for (int s = 0; s < p; s++) wr(step_addr(s), step_data(s));
        if (k == 0) wr(step_addr(p), step_data(p) ^ 8'h01);
        else        wr(step_addr(p) ^ 12'h001, step_data(p));
        chk("R4 no pulse after break", n_chip + n_sect, 0);
        chk("R4 idle after break", busy, 0);
        wr(12'h555, 8'h10);
        chk("R4 stray final write", n_chip + n_sect, 0);
        prefix(); wr(12'h555, 8'h10);
        chk("R4 recovery chip pulse", n_chip, 1);
        done_pulse();
      end
    end

    // R5 chip code at wrong address
    clear_counts();
    prefix(); wr(12'h2AA, 8'h10);
    chk("R5 chip code wrong addr", n_chip + n_sect, 0);
    chk("R5 busy low", busy, 0);

    // R9 held-low enable takes nothing until it rises
    clear_counts();
    prefix();
    @(negedge clk); addr = 12'h555; data = 8'h10; we_n = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 no write while low", n_chip, 0);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 write on rise", n_chip, 1);
    done_pulse();

    // R10 done while idle
    done_pulse();
    chk("R10 busy after idle done", busy, 0);
    clear_counts();
    prefix(); wr(12'h777, 8'h30);
    chk("R10 sequence still accepted", n_sect, 1);

    // R8 reset aborts
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R8 busy cleared by reset", busy, 0);
    chk("R8 sector_addr cleared", sector_addr, 0);
    @(negedge clk); rst_n = 1'b1;
    clear_counts();
    prefix(); wr(12'h555, 8'h10);
    chk("R8 accepted after reset", n_chip, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule